// File: doc/BRIEF.md
# Configuration EEPROM Byte-Read Controller

This block lets software fetch single bytes from a small configuration EEPROM through two 32-bit registers. Software writes a command word that sets the start/busy flag, gives a read opcode and gives a 9-bit byte address. The controller then places a request on a simple memory-side port. It waits for the response and clears busy when it is done. The fetched byte appears in the low byte of a data register. Software polls the command register until busy is clear or the timeout flag is set.

After reset the controller runs a presence probe on its own. This is one read of a fixed byte address. If the memory answers within the wait window, a loaded flag is set. That flag tells software that an EEPROM is fitted and that its contents were loaded. Every access has a bounded wait. If the memory stays silent for the whole window, the access is abandoned and a timeout flag is raised. That flag stays set until the next command is accepted.

Top module: `eerd_ctrl`

## Requirements
- R1: During reset and right after it, the command register reads busy (bit 31) = 1, timeout (bit 10) = 0 and loaded (bit 9) = 0, and the data register reads 0. The probe request is already raised, with `mem_addr` = LOAD_ADDR.
- R2: The probe never writes the data register. If the probe is answered, loaded becomes 1 and busy clears. If it is not answered within TIMEOUT_CYCLES cycles, loaded stays 0 and timeout becomes 1.
- R3: A command is accepted when three conditions hold on the same cycle: the write sets bit 31, bits 30:28 hold the read opcode 000, and busy is clear. From the next cycle on, busy reads 1, `mem_req` is high, `mem_addr` equals write bits 8:0, and command bits 8:0 read back that address.
- R4: A response sampled while waiting puts `mem_rsp_data` into data bits 7:0, with bits 31:8 at zero, and clears busy and `mem_req` on that same edge. A response with latency L (where `rsp_valid` rises L cycles after the first cycle the request is seen) keeps busy high for L+2 cycles.
- R5: When no response arrives by the TIMEOUT_CYCLES-th cycle of waiting, busy and `mem_req` drop after exactly TIMEOUT_CYCLES cycles. The timeout flag is set and the data register keeps its old value. A response on that last cycle wins over the timeout.
- R6: The timeout flag stays set across idle cycles and is cleared when the next command is accepted.
- R7: A command write made while busy is set has no effect. The address in flight, the result and the request traffic are unchanged.
- R8: A write with bit 31 = 0, or with a nonzero opcode in bits 30:28, starts nothing and changes no register field.
- R9: `mem_req` is high only while busy is set, and `mem_addr` does not change while a request is held.
- R10: Commands never change the loaded flag; only the probe after reset sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr_en | input | 1 | Write strobe for the command register |
| cmd_wr_data | input | 32 | Command word: bit 31 start, 30:28 opcode, 8:0 byte address |
| cmd_rd_data | output | 32 | Command/status readback: 31 busy, 10 timeout, 9 loaded, 8:0 address |
| data_rd_data | output | 32 | Data register; the fetched byte is in bits 7:0 |
| mem_req | output | 1 | Read request, held until the response or the timeout |
| mem_addr | output | 9 | Byte address of the request |
| mem_rsp_valid | input | 1 | Response strobe from the memory side |
| mem_rsp_data | input | 8 | Response byte |

## Verification
The assertions assume that `mem_rsp_valid` is a one-cycle pulse per request. They also assume that a pulse arriving while no request is held carries no meaning, so the controller must ignore it. The bench memory model counts cycles from the first cycle it sees `mem_req` and raises exactly one pulse at the programmed latency. It drops any late pulse on the following cycle. Software-side writes follow the poll-before-issue rule, except in the directed cases that deliberately write while busy or write with illegal start and opcode fields.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

   localparam int REG_W        = 32;
   localparam int ADDR_W       = 9;
   localparam int BYTE_W       = 8;
   localparam int OP_W         = 3;

   localparam int BIT_BUSY     = 31;
   localparam int OP_LSB       = 28;
   localparam int BIT_TMO      = 10;
   localparam int BIT_LOADED   = 9;

   localparam logic [OP_W-1:0] OP_READ = 3'b000;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } eerd_state_t;

endpackage

// File: rtl/eerd_cmd_decode.sv
module eerd_cmd_decode
   import eerd_pkg::*;
(
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              busy,
   output logic              accept,
   output logic [ADDR_W-1:0] cmd_addr
);

   logic            start_bit;
   logic [OP_W-1:0] opcode;
   logic            unused_fields;

   if (OP_LSB + OP_W != BIT_BUSY) begin : g_bad_op_field
      $error("opcode field must sit directly below the busy bit");
   end
   if (BIT_TMO <= ADDR_W || BIT_LOADED < ADDR_W) begin : g_bad_flag_pos
      $error("status flags overlap the address field");
   end

   always_comb begin
      start_bit = wr_data[BIT_BUSY];
      opcode    = wr_data[OP_LSB +: OP_W];
      cmd_addr  = wr_data[ADDR_W-1:0];
      accept    = wr_en && start_bit && (opcode == OP_READ) && !busy;
   end

   assign unused_fields = ^wr_data[OP_LSB-1:ADDR_W];

endmodule

// File: rtl/eerd_wait_timer.sv
module eerd_wait_timer #(
   parameter int unsigned LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);

   localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("LIMIT must be at least one cycle");
   end

   if (LIMIT == 1) begin : g_single
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign expire     = run;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (!run) begin
            cnt_q <= '0;
         end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign expire = run && (cnt_q == LAST);

      a_r5_count_resets_idle: assert property (@(posedge clk) disable iff (!rst_n)
         !run |=> (cnt_q == '0));
   end

endmodule

// File: rtl/eerd_seq.sv
module eerd_seq
   import eerd_pkg::*;
#(
   parameter logic [ADDR_W-1:0] LOAD_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              rsp_valid,
   input  logic [BYTE_W-1:0] rsp_data,
   input  logic              expire,
   output logic              waiting,
   output logic              busy,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] data_byte,
   output logic              tmo_flag,
   output logic              loaded_flag
);

   eerd_state_t       state_q;
   logic              probe_q;
   logic              busy_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BYTE_W-1:0] data_q;
   logic              tmo_q;
   logic              loaded_q;
   logic              got_rsp;
   logic              gave_up;

   always_comb begin
      waiting = (state_q == ST_WAIT);
      got_rsp = waiting && rsp_valid;
      gave_up = waiting && !rsp_valid && expire;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_WAIT;
         probe_q  <= 1'b1;
         busy_q   <= 1'b1;
         addr_q   <= LOAD_ADDR;
         data_q   <= '0;
         tmo_q    <= 1'b0;
         loaded_q <= 1'b0;
      end else if (accept) begin
         state_q  <= ST_WAIT;
         probe_q  <= 1'b0;
         busy_q   <= 1'b1;
         addr_q   <= cmd_addr;
         tmo_q    <= 1'b0;
      end else if (got_rsp) begin
         state_q  <= ST_IDLE;
         busy_q   <= 1'b0;
         if (probe_q) begin
            loaded_q <= 1'b1;
         end else begin
            data_q   <= rsp_data;
         end
      end else if (gave_up) begin
         state_q  <= ST_IDLE;
         busy_q   <= 1'b0;
         tmo_q    <= 1'b1;
      end
   end

   assign busy        = busy_q;
   assign mem_req     = waiting;
   assign mem_addr    = addr_q;
   assign data_byte   = data_q;
   assign tmo_flag    = tmo_q;
   assign loaded_flag = loaded_q;

   // R9: request only while busy, address held for the whole request
   a_r9_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy_q);
   a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req)) |-> $stable(mem_addr));
   // R4: a sampled response ends the access on that edge
   a_r4_rsp_completes: assert property (@(posedge clk) disable iff (!rst_n)
      got_rsp |=> (!busy_q && !mem_req));
   // R5: expiry ends the access, flags it and keeps the data
   a_r5_expire_flags: assert property (@(posedge clk) disable iff (!rst_n)
      gave_up |=> (!busy_q && tmo_q && $stable(data_q)));
   // R6: an accepted command clears the sticky flag
   a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy_q && !tmo_q));
   // R10: loaded never falls once set
   a_r10_loaded_holds: assert property (@(posedge clk) disable iff (!rst_n)
      loaded_q |=> loaded_q);

endmodule

// File: rtl/eerd_ctrl.sv
module eerd_ctrl
   import eerd_pkg::*;
#(
   parameter int unsigned       TIMEOUT_CYCLES = 1024,
   parameter logic [ADDR_W-1:0] LOAD_ADDR      = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr_en,
   input  logic [REG_W-1:0]  cmd_wr_data,
   output logic [REG_W-1:0]  cmd_rd_data,
   output logic [REG_W-1:0]  data_rd_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rsp_valid,
   input  logic [BYTE_W-1:0] mem_rsp_data
);

   logic              accept;
   logic [ADDR_W-1:0] cmd_addr;
   logic              busy;
   logic              waiting;
   logic              expire;
   logic [BYTE_W-1:0] data_byte;
   logic              tmo_flag;
   logic              loaded_flag;

   eerd_cmd_decode u_decode (
      .wr_en    (cmd_wr_en),
      .wr_data  (cmd_wr_data),
      .busy     (busy),
      .accept   (accept),
      .cmd_addr (cmd_addr)
   );

   eerd_wait_timer #(
      .LIMIT (TIMEOUT_CYCLES)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (waiting),
      .expire (expire)
   );

   eerd_seq #(
      .LOAD_ADDR (LOAD_ADDR)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .cmd_addr    (cmd_addr),
      .rsp_valid   (mem_rsp_valid),
      .rsp_data    (mem_rsp_data),
      .expire      (expire),
      .waiting     (waiting),
      .busy        (busy),
      .mem_req     (mem_req),
      .mem_addr    (mem_addr),
      .data_byte   (data_byte),
      .tmo_flag    (tmo_flag),
      .loaded_flag (loaded_flag)
   );

   always_comb begin
      cmd_rd_data               = '0;
      cmd_rd_data[BIT_BUSY]     = busy;
      cmd_rd_data[BIT_TMO]      = tmo_flag;
      cmd_rd_data[BIT_LOADED]   = loaded_flag;
      cmd_rd_data[ADDR_W-1:0]   = mem_addr;
      data_rd_data              = '0;
      data_rd_data[BYTE_W-1:0]  = data_byte;
   end

   // R7: writes during an access leave the address field alone
   a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_wr_en) |=> $stable(cmd_rd_data[ADDR_W-1:0]));
   // R8: a write without the start bit never raises busy
   a_r8_no_start_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_wr_en && !cmd_wr_data[BIT_BUSY]) |=> !cmd_rd_data[BIT_BUSY]);

endmodule

// File: tb/eerd_ctrl_bench.sv
module eerd_ctrl_bench;

   localparam int TMO = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_wr_en;
   logic [31:0] cmd_wr_data;
   logic [31:0] cmd_rd_data;
   logic [31:0] data_rd_data;
   logic        mem_req;
   logic [8:0]  mem_addr;
   logic        mem_rsp_valid;
   logic [7:0]  mem_rsp_data;

   int checks = 0;
   int errors = 0;

   // memory model controls
   logic       present;
   logic [7:0] lat_cfg;
   logic [7:0] wcnt;

   always #2 clk = ~clk;

   eerd_ctrl #(
      .TIMEOUT_CYCLES (TMO),
      .LOAD_ADDR      (9'h000)
   ) u_eerd_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_wr_en     (cmd_wr_en),
      .cmd_wr_data   (cmd_wr_data),
      .cmd_rd_data   (cmd_rd_data),
      .data_rd_data  (data_rd_data),
      .mem_req       (mem_req),
      .mem_addr      (mem_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data)
   );

   function automatic logic [7:0] mem_byte(input logic [8:0] a);
      logic [15:0] t;
      t = {7'd0, a} * 16'd37;
      return t[7:0] ^ {a[8], a[7:1]} ^ 8'hC3;
   endfunction

   always @(posedge clk) begin
      if (!rst_n || !mem_req) begin
         wcnt          <= 8'd0;
         mem_rsp_valid <= 1'b0;
      end else begin
         wcnt <= wcnt + 8'd1;
         if (present && wcnt == lat_cfg) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem_byte(mem_addr);
         end else begin
            mem_rsp_valid <= 1'b0;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   int busy_cycles;

   task automatic wait_idle();
      busy_cycles = 0;
      while (cmd_rd_data[31] && busy_cycles < 1000) begin
         busy_cycles++;
         @(negedge clk);
      end
   endtask

   task automatic write_cmd(input logic [31:0] w);
      @(negedge clk);
      cmd_wr_en   = 1'b1;
      cmd_wr_data = w;
      @(negedge clk);
      cmd_wr_en   = 1'b0;
   endtask

   // {addr[8:0], latency[7:0], expect_timeout}
   localparam logic [17:0] VECS [0:6] = '{
      {9'h001, 8'd0,   1'b0},
      {9'h0A5, 8'd3,   1'b0},
      {9'h1FF, 8'd14,  1'b0},
      {9'h100, 8'd15,  1'b1},
      {9'h042, 8'd1,   1'b0},
      {9'h033, 8'd255, 1'b1},
      {9'h155, 8'd7,   1'b0}
   };

   logic [7:0] exp_data;

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n       = 1'b0;
      present     = 1'b1;
      lat_cfg     = 8'd3;
      cmd_wr_en   = 1'b0;
      cmd_wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, probe raised
      chk("R1 busy",    {31'd0, cmd_rd_data[31]}, 32'd1);
      chk("R1 tmo",     {31'd0, cmd_rd_data[10]}, 32'd0);
      chk("R1 loaded",  {31'd0, cmd_rd_data[9]},  32'd0);
      chk("R1 data",    data_rd_data, 32'd0);
      chk("R1 req",     {31'd0, mem_req}, 32'd1);
      chk("R1 addr",    {23'd0, mem_addr}, 32'd0);

      // R2 probe answered
      wait_idle();
      chk("R2 probe cycles", busy_cycles, 32'd5);
      chk("R2 loaded",  {31'd0, cmd_rd_data[9]},  32'd1);
      chk("R2 tmo",     {31'd0, cmd_rd_data[10]}, 32'd0);
      chk("R2 data untouched", data_rd_data, 32'd0);
      exp_data = 8'h00;

      // table walk: R3 R4 R5 R6 R10
      for (int i = 0; i < 7; i++) begin
         logic [8:0] a;
         logic [7:0] l;
         logic       t;
         {a, l, t} = VECS[i];
         lat_cfg = l;
         repeat (2) @(negedge clk);
         write_cmd({1'b1, 3'b000, 19'd0, a});
         chk("R3 busy set", {31'd0, cmd_rd_data[31]}, 32'd1);
         chk("R3 req",      {31'd0, mem_req}, 32'd1);
         chk("R3 mem_addr", {23'd0, mem_addr}, {23'd0, a});
         chk("R6 tmo cleared on start", {31'd0, cmd_rd_data[10]}, 32'd0);
         wait_idle();
         if (!t) exp_data = mem_byte(a);
         chk(t ? "R5 cycles" : "R4 cycles", busy_cycles, t ? TMO : 32'(l) + 32'd2);
         chk(t ? "R5 data kept" : "R4 data", data_rd_data, {24'd0, exp_data});
         chk(t ? "R5 tmo set" : "R4 tmo clear", {31'd0, cmd_rd_data[10]}, {31'd0, t});
         chk("R3 addr readback", {23'd0, cmd_rd_data[8:0]}, {23'd0, a});
         chk("R9 req dropped", {31'd0, mem_req}, 32'd0);
         chk("R10 loaded", {31'd0, cmd_rd_data[9]}, 32'd1);
         if (t) begin
            repeat (3) @(negedge clk);
            chk("R6 tmo sticky", {31'd0, cmd_rd_data[10]}, 32'd1);
         end
      end

      // R7 write while busy
      lat_cfg = 8'd5;
      repeat (2) @(negedge clk);
      write_cmd({1'b1, 3'b000, 19'd0, 9'h0C0});
      write_cmd({1'b1, 3'b000, 19'd0, 9'h011});
      chk("R7 addr in flight", {23'd0, mem_addr}, 32'h0C0);
      wait_idle();
      chk("R7 addr kept", {23'd0, cmd_rd_data[8:0]}, 32'h0C0);
      chk("R7 data of first", data_rd_data, {24'd0, mem_byte(9'h0C0)});
      begin
         int reqs = 0;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (mem_req) reqs++;
         end
         chk("R7 no second request", reqs, 32'd0);
      end

      // R8 missing start bit
      write_cmd({1'b0, 3'b000, 19'd0, 9'h077});
      chk("R8 no start busy", {31'd0, cmd_rd_data[31]}, 32'd0);
      chk("R8 no start req", {31'd0, mem_req}, 32'd0);
      chk("R8 no start addr", {23'd0, cmd_rd_data[8:0]}, 32'h0C0);
      // R8 nonzero opcode
      write_cmd({1'b1, 3'b010, 19'd0, 9'h066});
      @(negedge clk);
      chk("R8 bad op busy", {31'd0, cmd_rd_data[31]}, 32'd0);
      chk("R8 bad op req", {31'd0, mem_req}, 32'd0);
      chk("R8 bad op addr", {23'd0, cmd_rd_data[8:0]}, 32'h0C0);
      chk("R8 bad op data", data_rd_data, {24'd0, mem_byte(9'h0C0)});

      // R2 probe with no EEPROM fitted
      present = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      wait_idle();
      chk("R2 absent cycles", busy_cycles, TMO);
      chk("R2 absent loaded", {31'd0, cmd_rd_data[9]},  32'd0);
      chk("R2 absent tmo",    {31'd0, cmd_rd_data[10]}, 32'd1);
      chk("R2 absent data",   data_rd_data, 32'd0);

      // R10 command cannot set loaded
      write_cmd({1'b1, 3'b000, 19'd0, 9'h010});
      wait_idle();
      chk("R10 still unloaded", {31'd0, cmd_rd_data[9]}, 32'd0);
      chk("R5 absent timeout", {31'd0, cmd_rd_data[10]}, 32'd1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule